// File: doc/BRIEF.md
# Cascade Frame Shifter

This block lets several stereo converters share one receiver data line. Each device holds its own left and right results in a 64-bit shift register. A frame-sync pulse, seen on a rising bit-clock edge, loads that register with both results. Each result is placed in a fixed 32-bit subframe: left in the first, right in the second. Each subframe starts with the result's most significant bit, and every position below the selected word width is zero.

On every later rising edge the register shifts one place toward the receiver and takes one bit from the upstream device's data input at its tail. The output bit is updated on the falling edge. When instances are chained, the device nearest the receiver first sends its own two words and then passes on, in order, the words of each device further up the chain. The device at the far end has its data input tied low.

The block runs on a system clock. The bit clock, frame sync and upstream data pass through a short synchronizer, and an edge detector derives the rising and falling events. The framing is always left-justified, most significant bit first. No format input exists.

Top module: `casc_frame_shifter`

## Requirements
- R1: While reset is high, and in the cycle after it, the serial output is 0 and the shift register is all zeros. After reset, 64 bit periods with no frame sync and a low upstream input give only zeros on the output.
- R2: A loaded frame carries the left result in its first 32 bits and the right result in the next 32 bits. Each result is sent most significant bit first. The first bit after the sync is bit 23 of the left sample.
- R3: The width code selects how many top bits of the 24-bit sample are kept: 00 keeps 24, 01 keeps 20, 10 keeps 16, and the spare value 11 keeps 24. Within each 32-bit subframe, every bit below the kept bits is 0.
- R4: The sample and width inputs are captured only on a rising bit-clock edge while the frame sync is high. Changing them on other edges does not alter the bits sent.
- R5: On each rising bit-clock edge without a frame sync, the register shifts toward the output and takes the upstream data bit at its tail. A device therefore sends its upstream neighbour's bits right after its own 64 bits. Once all frames have passed, a chain whose far end is tied low sends zeros.
- R6: With four chained devices, the receiver gets eight 32-bit words in this order: device 1 left, device 1 right, device 2 left, device 2 right, and so on up to device 4 right. Device 1 is the one nearest the receiver.
- R7: The serial output changes only after a falling bit-clock edge. It holds its value across the rising edge on which the receiver samples it.
- R8: A frame sync reloads the register at any point of the stream. Bits not yet sent from the previous frame are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync pulse, seen on a rising bit-clock edge |
| din_i | input | 1 | Serial data from the upstream device |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| width_i | input | 2 | Word width code |
| dout_o | output | 1 | Serial data toward the receiver |

## Verification
The bench builds four instances with the default parameters: 24-bit samples, 32-bit subframes and a two-stage synchronizer. They are chained with the far input tied low, and the bit clock is sixteen system clocks wide. This exposes the whole 256-bit chain order, the tail of zeros after the last device, and a mix of width codes per device, including the spare code. A shortened frame followed by an early sync exercises a reload while bits are still left in every register.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int DEF_SAMPLE_W   = 24;
    localparam int DEF_SUBFRAME_W = 32;
    localparam int DEF_SYNC       = 2;

    typedef enum logic [1:0] {
        WC_24  = 2'b00,
        WC_20  = 2'b01,
        WC_16  = 2'b10,
        WC_RSV = 2'b11
    } width_code_e;

    // events derived from the synchronized bit clock
    typedef struct packed {
        logic rise;
        logic fall;
        logic fsync;
        logic din;
    } bit_evt_t;

    function automatic int unsigned width_bits(width_code_e w);
        case (w)
            WC_20:   return 20;
            WC_16:   return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/cfs_edge_sync.sv
module cfs_edge_sync
    import cfs_pkg::*;
#(
    parameter int STAGES = DEF_SYNC
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_i,
    input  logic     fsync_i,
    input  logic     din_i,
    output bit_evt_t evt_o
);

    // lane 0 = bit clock, lane 1 = frame sync, lane 2 = upstream data
    logic [STAGES-1:0][2:0] pipe_q;
    logic                   bclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q      <= '0;
            bclk_prev_q <= 1'b0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                pipe_q[i] <= pipe_q[i-1];
            end
            pipe_q[0]   <= {din_i, fsync_i, bclk_i};
            bclk_prev_q <= pipe_q[STAGES-1][0];
        end
    end

    always_comb begin
        evt_o.rise  = pipe_q[STAGES-1][0] & ~bclk_prev_q;
        evt_o.fall  = ~pipe_q[STAGES-1][0] & bclk_prev_q;
        evt_o.fsync = pipe_q[STAGES-1][1];
        evt_o.din   = pipe_q[STAGES-1][2];
    end

endmodule

// File: rtl/cfs_packer.sv
module cfs_packer
    import cfs_pkg::*;
#(
    parameter int SAMPLE_W   = DEF_SAMPLE_W,
    parameter int SUBFRAME_W = DEF_SUBFRAME_W,
    localparam int FRAME_W   = 2 * SUBFRAME_W,
    localparam int PAD       = SUBFRAME_W - SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic [1:0]          width_i,
    output logic [FRAME_W-1:0]  frame_o
);

    width_code_e                      wcode;
    logic [SUBFRAME_W-1:0]            keep_mask;
    logic [1:0][SAMPLE_W-1:0]         smp;
    logic [1:0][SUBFRAME_W-1:0]       lane;

    assign wcode  = width_code_e'(width_i);
    assign smp[1] = left_i;
    assign smp[0] = right_i;

    always_comb begin
        int unsigned nb;
        nb = width_bits(wcode);
        if (nb > SAMPLE_W) nb = SAMPLE_W;
        for (int i = 0; i < SUBFRAME_W; i++) begin
            keep_mask[i] = (i >= (SUBFRAME_W - int'(nb)));
        end
    end

    // one lane per channel: top-align the sample, clear bits below the width
    for (genvar g = 0; g < 2; g++) begin : gen_lane
        assign lane[g] = (SUBFRAME_W'(smp[g]) << PAD) & keep_mask;
    end

    assign frame_o = lane;

    AST_ZERO_FILL_16: assert property (@(posedge clk) disable iff (rst)
        (wcode == WC_16) |-> (frame_o[FRAME_W-17:SUBFRAME_W] == '0 &&
                              frame_o[SUBFRAME_W-17:0] == '0)); // R3

endmodule

// File: rtl/cfs_shifter.sv
module cfs_shifter
    import cfs_pkg::*;
#(
    parameter int FRAME_W = 2 * DEF_SUBFRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  bit_evt_t           evt_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               dout_o
);

    logic [FRAME_W-1:0] shreg_q;
    logic               dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            dout_q  <= 1'b0;
        end else begin
            if (evt_i.rise) begin
                if (evt_i.fsync) shreg_q <= frame_i;
                else             shreg_q <= {shreg_q[FRAME_W-2:0], evt_i.din};
            end
            if (evt_i.fall) dout_q <= shreg_q[FRAME_W-1];
        end
    end

    assign dout_o = dout_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (dout_q == 1'b0 && shreg_q == '0)); // R1
    AST_LOAD_FRAME: assert property (@(posedge clk) disable iff (rst)
        (evt_i.rise && evt_i.fsync) |=> shreg_q == $past(frame_i)); // R4
    AST_SHIFT_TAIL: assert property (@(posedge clk) disable iff (rst)
        (evt_i.rise && !evt_i.fsync) |=> (shreg_q[0] == $past(evt_i.din) &&
            shreg_q[FRAME_W-1:1] == $past(shreg_q[FRAME_W-2:0]))); // R5
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !evt_i.fall |=> $stable(dout_q)); // R7
    AST_DOUT_FROM_HEAD: assert property (@(posedge clk) disable iff (rst)
        evt_i.fall |=> dout_q == $past(shreg_q[FRAME_W-1])); // R2

endmodule

// File: rtl/casc_frame_shifter.sv
module casc_frame_shifter
    import cfs_pkg::*;
#(
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int SUBFRAME_W  = DEF_SUBFRAME_W,
    parameter int SYNC_STAGES = DEF_SYNC,
    localparam int FRAME_W    = 2 * SUBFRAME_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_i,
    input  logic                fsync_i,
    input  logic                din_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic [1:0]          width_i,
    output logic                dout_o
);

    bit_evt_t           evt;
    logic [FRAME_W-1:0] frame;

    cfs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bclk_i  (bclk_i),
        .fsync_i (fsync_i),
        .din_i   (din_i),
        .evt_o   (evt)
    );

    cfs_packer #(.SAMPLE_W(SAMPLE_W), .SUBFRAME_W(SUBFRAME_W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .left_i  (left_i),
        .right_i (right_i),
        .width_i (width_i),
        .frame_o (frame)
    );

    cfs_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .frame_i (frame),
        .dout_o  (dout_o)
    );

endmodule

// File: tb/casc_frame_shifter_tb.sv
module casc_frame_shifter_tb;

    localparam int HALF = 8;
    localparam int NDEV = 4;
    localparam int SW   = 24;
    localparam int SUB  = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          bclk;
    logic          fsync;
    logic [SW-1:0] lft [NDEV];
    logic [SW-1:0] rgt [NDEV];
    logic [1:0]    wc  [NDEV];
    logic [NDEV:0] link;   // link[k] = output of device k+1, link[NDEV] = far end

    int checks   = 0;
    int failures = 0;

    assign link[NDEV] = 1'b0;

    casc_frame_shifter u_dut (
        .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_i(fsync), .din_i(link[1]),
        .left_i(lft[0]), .right_i(rgt[0]), .width_i(wc[0]), .dout_o(link[0])
    );

    for (genvar g = 1; g < NDEV; g++) begin : gen_dev
        casc_frame_shifter u_dev (
            .clk(clk), .rst(rst), .bclk_i(bclk), .fsync_i(fsync), .din_i(link[g+1]),
            .left_i(lft[g]), .right_i(rgt[g]), .width_i(wc[g]), .dout_o(link[g])
        );
    end

    task automatic check(input logic ok, input string msg,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [31:0] exp_sub(input logic [SW-1:0] s, input logic [1:0] w);
        int nb;
        logic [31:0] v;
        nb = (w == 2'b01) ? 20 : (w == 2'b10) ? 16 : 24;
        v  = {s, 8'h00};
        for (int i = 0; i < SUB - nb; i++) v[i] = 1'b0;
        return v;
    endfunction

    // one bit period; returns the bit seen just before the rising edge
    task automatic bit_period(input logic fs, output logic smp);
        @(negedge clk);
        bclk  = 1'b0;
        fsync = fs;
        repeat (HALF) @(negedge clk);
        smp  = link[0];
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        check(link[0] === smp, "R7 output held across rising edge", 32'(link[0]), 32'(smp));
        repeat (HALF - 5) @(negedge clk);
    endtask

    // load, then receive nwords 32-bit words and compare with the chain order
    task automatic run_frame(input int nwords, input string tag);
        logic        b;
        logic [31:0] word;
        logic [31:0] expw [NDEV*2+1];
        for (int d = 0; d < NDEV; d++) begin
            expw[2*d]   = exp_sub(lft[d], wc[d]);
            expw[2*d+1] = exp_sub(rgt[d], wc[d]);
        end
        expw[NDEV*2] = 32'h0;
        bit_period(1'b1, b);
        // inputs may move after the load edge without effect
        for (int d = 0; d < NDEV; d++) begin
            lft[d] = ~lft[d];
            rgt[d] = rgt[d] ^ 24'h5A5A5A;
            wc[d]  = wc[d] + 2'd1;
        end
        for (int w = 0; w < nwords; w++) begin
            word = '0;
            for (int k = 0; k < SUB; k++) begin
                bit_period(1'b0, b);
                word = {word[30:0], b};
            end
            check(word === expw[w],
                  $sformatf("R2 R3 R4 R5 R6 %s word %0d", tag, w), word, expw[w]);
        end
    endtask

    initial begin
        logic b;
        logic all_zero;
        void'($urandom(32'd1234));
        rst   = 1'b1;
        bclk  = 1'b0;
        fsync = 1'b0;
        for (int d = 0; d < NDEV; d++) begin
            lft[d] = '0; rgt[d] = '0; wc[d] = 2'b00;
        end
        repeat (5) @(negedge clk);
        check(link[0] === 1'b0, "R1 output low in reset", 32'(link[0]), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(link[0] === 1'b0, "R1 output low after reset", 32'(link[0]), 32'h0);

        // no sync: register stays clear, samples are not captured (R1, R4)
        for (int d = 0; d < NDEV; d++) begin
            lft[d] = 24'hFFFFFF; rgt[d] = 24'hFFFFFF;
        end
        all_zero = 1'b1;
        for (int k = 0; k < 64; k++) begin
            bit_period(1'b0, b);
            if (b !== 1'b0) all_zero = 1'b0;
        end
        check(all_zero, "R1 R4 zeros without frame sync", 32'(all_zero), 32'h1);

        // directed: full-scale values, 24-bit width
        lft[0] = 24'h7FFFFF; rgt[0] = 24'h800001;
        lft[1] = 24'hA5A5A5; rgt[1] = 24'h000001;
        lft[2] = 24'h123456; rgt[2] = 24'hFEDCBA;
        lft[3] = 24'h800000; rgt[3] = 24'hFFFFFF;
        for (int d = 0; d < NDEV; d++) wc[d] = 2'b00;
        run_frame(NDEV * 2 + 1, "full24");

        // directed: mixed width codes including the spare one
        for (int d = 0; d < NDEV; d++) begin
            lft[d] = 24'hFFFFFF; rgt[d] = 24'hC3C3C3;
        end
        wc[0] = 2'b10; wc[1] = 2'b01; wc[2] = 2'b11; wc[3] = 2'b00;
        run_frame(NDEV * 2 + 1, "widths");

        // early sync after three words, then a full frame (R8)
        for (int d = 0; d < NDEV; d++) begin
            lft[d] = 24'h111111 * (d + 1); rgt[d] = 24'h0F0F0F; wc[d] = 2'b00;
        end
        run_frame(3, "R8 short");
        for (int d = 0; d < NDEV; d++) begin
            lft[d] = 24'h00F00F + 24'(d); rgt[d] = 24'h7E0000 >> d; wc[d] = 2'(d);
        end
        run_frame(NDEV * 2 + 1, "R8 reload");

        // random frames
        for (int f = 0; f < 6; f++) begin
            for (int d = 0; d < NDEV; d++) begin
                lft[d] = 24'($urandom);
                rgt[d] = 24'($urandom);
                wc[d]  = 2'($urandom);
            end
            run_frame(NDEV * 2 + 1, "random");
        end
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

endmodule